// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block sequences how a programmable device takes in its configuration over a slave serial link. It runs on a system clock. Four asynchronous pins reach it: a serial clock, a serial data bit, an active-low reset request and the sensed level of the shared open-drain DONE/PROG line. All four go through two-flop synchronisers before any edge detection. A divider turns the system clock into a slow timer tick. All request filtering and the clear interval are counted in these ticks.

After reset the controller sits in Clear for a fixed number of ticks. It then moves to Init and waits for the reset pin to be released before it enters Config. In Config it samples one data bit on each rising edge of the serial clock and expects a stop bit of 1 after every group of data bits. Two events end the load early. If the reset pin is held low for long enough, the load aborts and the controller returns to Clear. If a stop bit is missing, the controller enters Error and keeps INIT low. After the set number of frames it enters Done and releases DONE/PROG.

Outside Done, the block drives the DONE/PROG line low. A new load begins when that line falls and stays low for a minimum number of ticks. If the line is held low, a long enough low pulse on the reset pin does the same job. Writing the configuration memory is modelled only as a count of accepted data bits.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is Clear (0), init_drive_low_o and done_drive_low_o are 1, and bit_count_o is 0.
- R2: Clear lasts CLEAR_TICKS timer ticks and then moves to Init (1). Init moves to Config (2) only while the synchronised reset pin is high. INIT is released (init_drive_low_o=0) only in Config and Done.
- R3: In Config, each rising edge of cfg_clk_i samples cfg_data_i. The first DATA_BITS samples of a frame are data bits, and each one adds 1 to bit_count_o. The next sample is the stop bit.
- R4: After NUM_FRAMES frames whose stop bits are all 1, the state becomes Done (3), done_drive_low_o goes to 0 and INIT stays released.
- R5: A stop bit of 0 moves the state to Error (4) with init_drive_low_o=1, and leaves bit_count_o at DATA_BITS times the number of frames started.
- R6: In Done, a fall of prog_pin_i that stays low for REPROG_TICKS ticks moves the state to Clear. A low pulse shorter than that has no effect.
- R7: When prog_pin_i is low, a fall of reset_pin_ni that stays low for REPROG_TICKS ticks moves the state from Done or Error to Clear. In Done with prog_pin_i high, a reset pulse does not change the state.
- R8: In Config, reset_pin_ni held low for ABORT_TICKS ticks aborts the load to Clear. A shorter low pulse leaves the state and bit_count_o unchanged.
- R9: Clear sets bit_count_o to 0.
- R10: Done and Error are left only towards Clear. Done is entered only from Config, and so is Error.
- R11: Serial clock edges outside Config do not change bit_count_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| cfg_clk_i | input | 1 | Serial configuration clock (asynchronous) |
| cfg_data_i | input | 1 | Serial configuration data (asynchronous) |
| reset_pin_ni | input | 1 | Active-low reset request pin (asynchronous) |
| prog_pin_i | input | 1 | Sensed level of the wired DONE/PROG line |
| done_drive_low_o | output | 1 | 1 pulls DONE/PROG low; 0 releases it |
| init_drive_low_o | output | 1 | 1 pulls INIT low (device not initialised) |
| state_o | output | 3 | Clear=0, Init=1, Config=2, Done=3, Error=4 |
| bit_count_o | output | $clog2(DATA_BITS*NUM_FRAMES+1) | Accepted data bits of the current load |

## Verification
The assertions check on every cycle that the state graph is legal. Config is entered only with the reset pin high. Done and Error are reached only from Config and are left only to Clear. The bit count grows by at most one per cycle, stays frozen in Done and Error, and is zero in Clear. Only the bench scenarios can show that timing filters on each pin behave correctly, that stop-bit checking places the error at the right frame, and that the stuck-low reprogram path works. The bench covers the filters by holding each pin low for periods just below and well above its threshold, and covers the frame checking with a sweep of the missing stop bit over every frame position.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR  = 3'd0,
    ST_INIT   = 3'd1,
    ST_CONFIG = 3'd2,
    ST_DONE   = 3'd3,
    ST_ERROR  = 3'd4
  } state_e;
endpackage

// File: rtl/cfg_seq_sync.sv
module cfg_seq_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_o[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_o[g] <= meta_q[g];
      end
    end
  end
endmodule

// File: rtl/cfg_seq_tick.sv
module cfg_seq_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_seq_lowfilt.sv
// Pulses once when the line falls from a seen-high level and stays low for TICKS ticks.
module cfg_seq_lowfilt #(
  parameter int TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic fire_o
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_o  <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (line_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q && tick_i) begin
        if (cnt_q == CW'(TICKS - 1)) begin
          fire_o  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int TICK_DIV     = 4,
  parameter int REPROG_TICKS = 2,
  parameter int ABORT_TICKS  = 3,
  parameter int CLEAR_TICKS  = 4,
  parameter int DATA_BITS    = 8,
  parameter int NUM_FRAMES   = 4
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      cfg_clk_i,
  input  logic                                      cfg_data_i,
  input  logic                                      reset_pin_ni,
  input  logic                                      prog_pin_i,
  output logic                                      done_drive_low_o,
  output logic                                      init_drive_low_o,
  output logic [2:0]                                state_o,
  output logic [$clog2(DATA_BITS*NUM_FRAMES+1)-1:0] bit_count_o
);
  localparam int TOTAL_BITS = DATA_BITS * NUM_FRAMES;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam int POS_W      = $clog2(DATA_BITS + 1);
  localparam int FRM_W      = $clog2(NUM_FRAMES) + 1;
  localparam int CLR_W      = $clog2(CLEAR_TICKS + 1);

  logic [3:0] pins_s;
  logic       cclk_s, cdat_s, rst_s, prog_s;
  logic       tick, prog_fire, rst_fire, abort_fire, reprog;
  logic       cclk_prev_q, cclk_rise;

  state_e           state_q;
  logic [CLR_W-1:0] clr_cnt_q;
  logic [POS_W-1:0] pos_q;
  logic [FRM_W-1:0] frm_q;
  logic [CNT_W-1:0] bits_q;

  cfg_seq_sync #(.WIDTH(4)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cfg_clk_i, cfg_data_i, reset_pin_ni, prog_pin_i}),
    .sync_o (pins_s)
  );
  assign {cclk_s, cdat_s, rst_s, prog_s} = pins_s;

  cfg_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  cfg_seq_lowfilt #(.TICKS(REPROG_TICKS)) u_prog_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(prog_s), .fire_o(prog_fire)
  );

  cfg_seq_lowfilt #(.TICKS(REPROG_TICKS)) u_rst_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(rst_s), .fire_o(rst_fire)
  );

  cfg_seq_lowfilt #(.TICKS(ABORT_TICKS)) u_abort_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .line_i(rst_s), .fire_o(abort_fire)
  );

  // Reset only stands in for DONE/PROG when that line is held low
  assign reprog    = prog_fire | (rst_fire & ~prog_s);
  assign cclk_rise = cclk_s & ~cclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_CLEAR;
      clr_cnt_q   <= '0;
      pos_q       <= '0;
      frm_q       <= '0;
      bits_q      <= '0;
      cclk_prev_q <= 1'b0;
    end else begin
      cclk_prev_q <= cclk_s;
      unique case (state_q)
        ST_CLEAR: begin
          bits_q <= '0;
          pos_q  <= '0;
          frm_q  <= '0;
          if (tick) begin
            if (clr_cnt_q == CLR_W'(CLEAR_TICKS - 1)) begin
              clr_cnt_q <= '0;
              state_q   <= ST_INIT;
            end else begin
              clr_cnt_q <= clr_cnt_q + 1'b1;
            end
          end
        end
        ST_INIT: if (rst_s) state_q <= ST_CONFIG;
        ST_CONFIG: begin
          if (abort_fire) begin
            clr_cnt_q <= '0;
            state_q   <= ST_CLEAR;
          end else if (cclk_rise) begin
            if (pos_q == POS_W'(DATA_BITS)) begin
              pos_q <= '0;
              if (!cdat_s)                               state_q <= ST_ERROR;
              else if (frm_q == FRM_W'(NUM_FRAMES - 1))  state_q <= ST_DONE;
              else                                       frm_q   <= frm_q + 1'b1;
            end else begin
              pos_q  <= pos_q + 1'b1;
              bits_q <= bits_q + 1'b1;
            end
          end
        end
        ST_DONE, ST_ERROR: begin
          if (reprog) begin
            clr_cnt_q <= '0;
            state_q   <= ST_CLEAR;
          end
        end
        default: state_q <= ST_CLEAR;
      endcase
    end
  end

  assign state_o          = state_q;
  assign bit_count_o      = bits_q;
  assign done_drive_low_o = (state_q != ST_DONE);
  assign init_drive_low_o = (state_q != ST_CONFIG) && (state_q != ST_DONE);
endmodule

// File: rtl/cfg_seq_ctrl_chk.sv
module cfg_seq_ctrl_chk
  import cfg_seq_pkg::*;
#(
  parameter int TOTAL = 32,
  parameter int CW    = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    state_i,
  input logic [CW-1:0] bits_i,
  input logic          rst_s_i
);
  a_r2_config_needs_reset_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CONFIG && $past(state_i) != ST_CONFIG) |-> $past(rst_s_i));

  a_r10_done_from_config: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DONE && $past(state_i) != ST_DONE) |-> $past(state_i) == ST_CONFIG);

  a_r5_error_from_config: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ERROR && $past(state_i) != ST_ERROR) |-> $past(state_i) == ST_CONFIG);

  a_r10_exit_to_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(state_i) == ST_DONE || $past(state_i) == ST_ERROR) && state_i != $past(state_i))
    |-> state_i == ST_CLEAR);

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_CONFIG && state_i == ST_CONFIG)
    |-> (bits_i == $past(bits_i) || bits_i == $past(bits_i) + 1'b1));

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_i <= CW'(TOTAL));

  a_r11_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(state_i) == ST_DONE || $past(state_i) == ST_ERROR) && state_i == $past(state_i))
    |-> $stable(bits_i));

  a_r9_clear_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_CLEAR && state_i == ST_CLEAR) |-> bits_i == '0);
endmodule

bind cfg_seq_ctrl cfg_seq_ctrl_chk #(
  .TOTAL(DATA_BITS * NUM_FRAMES),
  .CW   ($clog2(DATA_BITS * NUM_FRAMES + 1))
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_i(state_o),
  .bits_i (bit_count_o),
  .rst_s_i(rst_s)
);

// File: tb/cfg_seq_ctrl_tb.sv
module cfg_seq_ctrl_tb;
  localparam int TD = 4, RP = 2, AB = 3, CL = 4, DB = 8, NF = 4;
  localparam int CW = $clog2(DB * NF + 1);
  localparam int S_CLEAR = 0, S_INIT = 1, S_CONFIG = 2, S_DONE = 3, S_ERROR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_clk = 1'b0, cfg_data = 1'b0, reset_pin_n = 1'b1, prog_ext = 1'b1;
  logic prog_line, done_low, init_low;
  logic [2:0]    state;
  logic [CW-1:0] bits;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  assign prog_line = prog_ext & ~done_low;  // wired-AND of the open-drain line

  cfg_seq_ctrl #(.TICK_DIV(TD), .REPROG_TICKS(RP), .ABORT_TICKS(AB),
                 .CLEAR_TICKS(CL), .DATA_BITS(DB), .NUM_FRAMES(NF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_clk_i(cfg_clk), .cfg_data_i(cfg_data),
    .reset_pin_ni(reset_pin_n), .prog_pin_i(prog_line),
    .done_drive_low_o(done_low), .init_drive_low_o(init_low),
    .state_o(state), .bit_count_o(bits)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    cfg_data = b;
    wait_cyc(3);
    cfg_clk = 1'b1;
    wait_cyc(4);
    cfg_clk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic send_frame(input logic [DB-1:0] d, input logic stop);
    for (int i = 0; i < DB; i++) send_bit(d[i]);
    send_bit(stop);
  endtask

  task automatic to_config();
    reset_pin_n = 1'b1;
    wait_cyc(CL * TD + 20);
  endtask

  initial begin
    wait_cyc(100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk("R1 state", state, S_CLEAR);
    chk("R1 init", init_low, 1);
    chk("R1 done", done_low, 1);
    chk("R1 count", bits, 0);
    rst_n = 1'b1;
    wait_cyc(8);
    chk("R2 still clear", state, S_CLEAR);
    wait_cyc(30);
    chk("R2 config", state, S_CONFIG);
    chk("R2 init released", init_low, 0);

    // good streams with several data patterns
    for (int p = 0; p < 3; p++) begin
      for (int f = 0; f < NF; f++) begin
        send_frame(DB'(8'hA5 ^ (p * 8'h3C) ^ f), 1'b1);
        if (f < NF - 1) chk("R3 count", bits, DB * (f + 1));
      end
      chk("R4 done", state, S_DONE);
      chk("R4 done released", done_low, 0);
      chk("R4 init released", init_low, 0);
      chk("R4 count", bits, DB * NF);
      send_bit(1'b1); send_bit(1'b0);
      chk("R11 count frozen", bits, DB * NF);
      // short prog pulse (one tick) ignored
      prog_ext = 1'b0; wait_cyc(TD); prog_ext = 1'b1; wait_cyc(20);
      chk("R6 short pulse", state, S_DONE);
      if (p == 0) begin
        // reset pulse with prog high ignored
        reset_pin_n = 1'b0; wait_cyc(24); reset_pin_n = 1'b1; wait_cyc(20);
        chk("R7 reset ignored", state, S_DONE);
      end
      prog_ext = 1'b0; wait_cyc(16);
      chk("R6 reprogram", state, S_CLEAR);
      chk("R9 wiped", bits, 0);
      prog_ext = 1'b1;
      wait_cyc(30);
      chk("R2 reload config", state, S_CONFIG);
    end

    // missing stop bit swept over every frame
    for (int k = 0; k < NF; k++) begin
      for (int f = 0; f < k; f++) send_frame(DB'(8'h5A + f), 1'b1);
      send_frame(DB'(8'hFF), 1'b0);
      chk("R5 error", state, S_ERROR);
      chk("R5 init low", init_low, 1);
      chk("R5 count", bits, DB * (k + 1));
      send_bit(1'b1); send_bit(1'b1);
      chk("R11 error frozen", bits, DB * (k + 1));
      reset_pin_n = 1'b0; wait_cyc(16);
      chk("R7 stuck-low reprogram", state, S_CLEAR);
      wait_cyc(40);
      chk("R2 held in init", state, S_INIT);
      chk("R2 init low", init_low, 1);
      to_config();
      chk("R2 config after error", state, S_CONFIG);
    end

    // abort in config
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    reset_pin_n = 1'b0; wait_cyc(2 * TD); reset_pin_n = 1'b1; wait_cyc(10);
    chk("R8 short ignored", state, S_CONFIG);
    chk("R8 count kept", bits, 5);
    reset_pin_n = 1'b0; wait_cyc(24);
    chk("R8 abort", state, S_CLEAR);
    chk("R9 abort wipes", bits, 0);
    wait_cyc(40);
    chk("R2 wait reset", state, S_INIT);
    to_config();
    chk("R2 config after abort", state, S_CONFIG);
    for (int f = 0; f < NF; f++) send_frame(DB'(f * 8'h11), 1'b1);
    chk("R4 reload done", state, S_DONE);
    chk("R4 reload count", bits, DB * NF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule